// File: doc/BRIEF.md
# ATAPI Device Task-File Controller

This block is the device side of a packet-command storage interface on a 16-bit host bus. It holds the task-file registers the host programs: feature, count, sector, two byte-count bytes, device, control and command. It runs the data port in both directions. A packet command arms the port to take a 12-byte command block, six 16-bit words long. The block then decodes that block after a short busy window and streams a response back through 16-bit reads.

Responses come from a computed 32-byte identity string or from a stub sector source. The stub turns the requested logical block address and block count into a deterministic word stream. An interrupt request is raised when a packet arrives, when a set-features command completes, and once per host-programmed block inside a read transfer. A status read acknowledges the interrupt only when the device is not busy. A mask bit in the control register gates the output pin without losing the pending request.

Host accesses take one cycle and have no back-pressure. `host_rdata` is combinational for the cycle in which `host_rd` is high. Any side effect of an access (FIFO-like pop, acknowledge, register write) happens at the clock edge that ends that cycle.

Top module: `atapi_tf_ctrl`

Register map (`host_addr`), write / read:
- 0: data port / data port
- 1: feature / error code
- 2: count / count
- 3: sector / sector
- 4: byte-count low / byte-count low
- 5: byte-count high / byte-count high
- 6: device / device
- 7: command / status (read acknowledges)
- 8: control / alternate status (read does not acknowledge)

Status byte layout: bit 7 BSY, bit 6 DRDY, bit 4 SERV, bit 3 DRQ, bit 0 ERR, and all other bits 0.

## Requirements
- R1: After reset, the status reads 0x00, the device register 0x00, the error code 0x00 and the sector register 0x81, and `irq` is low. The feature register is cleared to 0.
- R2: Any write to the command register (address 7) clears a pending interrupt, ERR and the error code. It also sets DRDY and SERV, so an idle status reads 0x50.
- R3: Command 0xA0 sets DRQ and accepts exactly six data-port writes, little-endian, so packet byte 0 is the low byte of word 0. On the sixth write DRQ drops, BSY is set for DECODE_CYCLES cycles and the interrupt is raised.
- R4: A read of address 7 returns the status and clears the pending interrupt only when BSY is 0 at that edge. A read of address 8 returns the same value and never clears it.
- R5: Control bit 1 set forces `irq` low while keeping the pending request. Clearing it while the request is pending drives `irq` high again.
- R6: Packet opcode 0x12 (identify) sends min({byte3,byte2}, 32) bytes of the identity string. Word k of that string is {0x41+2k, 0x40+2k}. The byte-count low register is overwritten with the sent length.
- R7: The block size is {byte-count high, byte-count low} in bytes, latched at decode. Each data read consumes 2 bytes. When a block runs out and data remains, the interrupt is raised and the block counter reloads. A block size of 0 raises no block interrupts.
- R8: When the last response word is read, DRQ clears. Data-port reads with no transfer active return 0 and change nothing.
- R9: Packet opcode 0x30 (read sector) takes a 24-bit block address from bytes 2..4 and a 24-bit block count from bytes 8..10, most significant byte first. With `medium_present` low, it sets ERR and error code 0x50 and leaves DRQ clear.
- R10: With `medium_present` high, read sector streams count × SECT_WORDS words. Word k equals address[15:0] + k, modulo 2^16.
- R11: Command 0xEF with feature 0x03 latches count[7:3] onto `xfer_class` and count[2:0] onto `xfer_mode`. Any other feature leaves both unchanged. The interrupt is raised in both cases.
- R12: Data-port writes while no packet is being collected are ignored: status and read data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| host_rdata | output | 16 | Read data for the current read cycle |
| medium_present | input | 1 | High when the stub sector source has a medium |
| irq | output | 1 | Interrupt request after masking |
| xfer_class | output | 5 | Latched transfer-mode class |
| xfer_mode | output | 3 | Latched transfer-mode number |

## Verification
The hardest state to reach from the ports is a status read that lands inside the busy window while an interrupt is pending. In that window the read must return BSY and leave the request alone. The bench issues the sixth packet word and then schedules back-to-back status reads, so that the first reads straddle the decode edges and a later one falls just after BSY clears, which is where the acknowledge must happen. Block interrupts are reached by programming a block size smaller than the response and checking `irq` after every word read.

// File: rtl/atapi_tf_pkg.sv
package atapi_tf_pkg;
  localparam logic [3:0] ADR_DATA    = 4'd0;
  localparam logic [3:0] ADR_ERRFEAT = 4'd1;
  localparam logic [3:0] ADR_COUNT   = 4'd2;
  localparam logic [3:0] ADR_SECTOR  = 4'd3;
  localparam logic [3:0] ADR_BCLO    = 4'd4;
  localparam logic [3:0] ADR_BCHI    = 4'd5;
  localparam logic [3:0] ADR_DEVICE  = 4'd6;
  localparam logic [3:0] ADR_STATCMD = 4'd7;
  localparam logic [3:0] ADR_ALTCTL  = 4'd8;

  localparam logic [7:0] CMD_PACKET   = 8'hA0;
  localparam logic [7:0] CMD_SETFEAT  = 8'hEF;
  localparam logic [7:0] FEAT_XFER    = 8'h03;
  localparam logic [7:0] PKT_IDENT    = 8'h12;
  localparam logic [7:0] PKT_READSEC  = 8'h30;
  localparam logic [7:0] ERR_NOMEDIUM = 8'h50;
  localparam logic [7:0] SECTOR_INIT  = 8'h81;

  localparam int PKT_BYTES   = 12;
  localparam int IDENT_BYTES = 32;
  localparam int NIEN_BIT    = 1;

  typedef enum logic {SRC_IDENT, SRC_SECTOR} src_e;

  // Identity string byte i is 0x40 + i; words are little-endian byte pairs.
  function automatic logic [15:0] ident_word(input logic [15:0] k);
    logic [7:0] lo;
    lo = 8'h40 + {k[6:0], 1'b0};
    return {lo + 8'd1, lo};
  endfunction
endpackage

// File: rtl/atapi_tf_irq.sv
module atapi_tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic mask,
  output logic pending,
  output logic line
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pending <= 1'b0;
    else if (raise) pending <= 1'b1;
    else if (clear) pending <= 1'b0;
  end

  assign line = pending & ~mask;
endmodule

// File: rtl/atapi_tf_pktbuf.sv
module atapi_tf_pktbuf #(
  parameter int PKT_WORDS = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            arm,
  input  logic                            cancel,
  input  logic                            wr,
  input  logic [15:0]                     wdata,
  output logic                            armed,
  output logic                            last,
  output logic [2*PKT_WORDS-1:0][7:0]     bytes
);
  localparam int IDX_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  logic [IDX_W-1:0] idx;
  logic [15:0]      words_q [PKT_WORDS];

  assign last = wr && armed && (idx == IDX_W'(PKT_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      idx   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      idx   <= '0;
    end else if (cancel) begin
      armed <= 1'b0;
    end else if (wr && armed) begin
      if (last) begin
        armed <= 1'b0;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr && armed) begin
      for (int i = 0; i < PKT_WORDS; i++)
        if (idx == IDX_W'(i)) words_q[i] <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < PKT_WORDS; i++) begin
      bytes[2*i]   = words_q[i][7:0];
      bytes[2*i+1] = words_q[i][15:8];
    end
  end
endmodule

// File: rtl/atapi_tf_rdstream.sv
module atapi_tf_rdstream
  import atapi_tf_pkg::*;
#(
  parameter int REM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  src_e             src,
  input  logic [REM_W-1:0] start_bytes,
  input  logic [15:0]      lba_lo,
  input  logic [15:0]      blk_bytes,
  input  logic             pop,
  input  logic             abort,
  output logic             active,
  output logic [15:0]      word,
  output logic             blk_irq,
  output logic             last
);
  logic [REM_W-1:0] remain;
  logic [15:0]      blk_left, blk_size, base, idx;
  src_e             src_q;
  logic             final_word;

  assign final_word = (remain <= REM_W'(2));
  assign last       = pop && active && final_word;
  assign blk_irq    = pop && active && !final_word && (blk_size != 16'd0)
                      && (blk_left <= 16'd2);
  assign word       = (src_q == SRC_IDENT) ? ident_word(idx) : (base + idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      remain   <= '0;
      blk_left <= '0;
      blk_size <= '0;
      base     <= '0;
      idx      <= '0;
      src_q    <= SRC_IDENT;
    end else if (abort) begin
      active <= 1'b0;
    end else if (start) begin
      active   <= (start_bytes != '0);
      remain   <= start_bytes;
      blk_left <= blk_bytes;
      blk_size <= blk_bytes;
      base     <= lba_lo;
      src_q    <= src;
      idx      <= '0;
    end else if (pop && active) begin
      idx    <= idx + 16'd1;
      remain <= remain - REM_W'(2);
      if (final_word) active <= 1'b0;
      if (blk_irq) blk_left <= blk_size;
      else         blk_left <= blk_left - 16'd2;
    end
  end
endmodule

// File: rtl/atapi_tf_ctrl.sv
module atapi_tf_ctrl
  import atapi_tf_pkg::*;
#(
  parameter int DECODE_CYCLES = 2,
  parameter int SECT_WORDS    = 4,
  parameter int REM_W         = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [3:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        medium_present,
  output logic        irq,
  output logic [4:0]  xfer_class,
  output logic [2:0]  xfer_mode
);
  localparam int PKT_WORDS  = PKT_BYTES / 2;
  localparam int SECT_BYTES = SECT_WORDS * 2;
  localparam int BUSY_W     = $clog2(DECODE_CYCLES + 1);

  logic [7:0] feat_q, count_q, sector_q, bclo_q, bchi_q, dev_q, err_q;
  logic       nien_q, drdy_q, serv_q, errbit_q, bsy_q;
  logic [BUSY_W-1:0] busy_cnt;

  logic wr_cmd, wr_data, rd_stat, pop;
  assign wr_cmd  = host_wr && (host_addr == ADR_STATCMD);
  assign wr_data = host_wr && (host_addr == ADR_DATA);
  assign rd_stat = host_rd && (host_addr == ADR_STATCMD);
  assign pop     = host_rd && (host_addr == ADR_DATA);

  // packet collection
  logic pkt_armed, pkt_last;
  logic [PKT_BYTES-1:0][7:0] pkt_b;

  atapi_tf_pktbuf #(.PKT_WORDS(PKT_WORDS)) pktbuf_i (
    .clk(clk), .rst_n(rst_n),
    .arm(wr_cmd && host_wdata[7:0] == CMD_PACKET),
    .cancel(wr_cmd), .wr(wr_data), .wdata(host_wdata),
    .armed(pkt_armed), .last(pkt_last), .bytes(pkt_b)
  );

  // packet decode
  logic        decode_now, is_ident, is_readsec, nomedium;
  logic [15:0] ident_len16, ident_len;
  logic [23:0] sec_lba, sec_count;
  logic [REM_W-1:0] st_bytes;
  logic        st_start;
  src_e        st_src;

  assign decode_now  = bsy_q && (busy_cnt == '0);
  assign is_ident    = pkt_b[0] == PKT_IDENT;
  assign is_readsec  = pkt_b[0] == PKT_READSEC;
  assign ident_len16 = {pkt_b[3], pkt_b[2]};
  assign ident_len   = (ident_len16 > 16'(IDENT_BYTES)) ? 16'(IDENT_BYTES) : ident_len16;
  assign sec_lba     = {pkt_b[2], pkt_b[3], pkt_b[4]};
  assign sec_count   = {pkt_b[8], pkt_b[9], pkt_b[10]};
  assign nomedium    = decode_now && is_readsec && !medium_present;
  assign st_start    = decode_now && (is_ident || (is_readsec && medium_present));
  assign st_src      = is_ident ? SRC_IDENT : SRC_SECTOR;
  assign st_bytes    = is_ident ? REM_W'(ident_len)
                                : REM_W'(sec_count) * REM_W'(SECT_BYTES);

  // response stream
  logic        st_active, st_blk_irq, st_last;
  logic [15:0] st_word;

  atapi_tf_rdstream #(.REM_W(REM_W)) stream_i (
    .clk(clk), .rst_n(rst_n),
    .start(st_start), .src(st_src), .start_bytes(st_bytes),
    .lba_lo(sec_lba[15:0]), .blk_bytes({bchi_q, bclo_q}),
    .pop(pop), .abort(wr_cmd),
    .active(st_active), .word(st_word), .blk_irq(st_blk_irq), .last(st_last)
  );

  // interrupt
  logic irq_raise, irq_clear, irq_pend;
  assign irq_raise = pkt_last || st_blk_irq
                     || (wr_cmd && host_wdata[7:0] == CMD_SETFEAT);
  assign irq_clear = wr_cmd || (rd_stat && !bsy_q);

  atapi_tf_irq irq_i (
    .clk(clk), .rst_n(rst_n), .raise(irq_raise), .clear(irq_clear),
    .mask(nien_q), .pending(irq_pend), .line(irq)
  );

  logic       drq;
  logic [7:0] status;
  assign drq    = pkt_armed || st_active;
  assign status = {bsy_q, drdy_q, 1'b0, serv_q, drq, 2'b00, errbit_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_q     <= 8'h00;
      count_q    <= 8'h00;
      sector_q   <= SECTOR_INIT;
      bclo_q     <= 8'h00;
      bchi_q     <= 8'h00;
      dev_q      <= 8'h00;
      err_q      <= 8'h00;
      nien_q     <= 1'b0;
      drdy_q     <= 1'b0;
      serv_q     <= 1'b0;
      errbit_q   <= 1'b0;
      bsy_q      <= 1'b0;
      busy_cnt   <= '0;
      xfer_class <= '0;
      xfer_mode  <= '0;
    end else begin
      if (host_wr) begin
        case (host_addr)
          ADR_ERRFEAT: feat_q   <= host_wdata[7:0];
          ADR_COUNT:   count_q  <= host_wdata[7:0];
          ADR_SECTOR:  sector_q <= host_wdata[7:0];
          ADR_BCLO:    bclo_q   <= host_wdata[7:0];
          ADR_BCHI:    bchi_q   <= host_wdata[7:0];
          ADR_DEVICE:  dev_q    <= host_wdata[7:0];
          ADR_ALTCTL:  nien_q   <= host_wdata[NIEN_BIT];
          default: ;
        endcase
      end
      if (pkt_last) begin
        bsy_q    <= 1'b1;
        busy_cnt <= BUSY_W'(DECODE_CYCLES - 1);
      end else if (bsy_q && busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
      end else if (decode_now) begin
        bsy_q <= 1'b0;
        if (is_ident) bclo_q <= ident_len[7:0];
        if (nomedium) begin
          errbit_q <= 1'b1;
          err_q    <= ERR_NOMEDIUM;
        end
      end
      if (wr_cmd) begin
        drdy_q   <= 1'b1;
        serv_q   <= 1'b1;
        errbit_q <= 1'b0;
        err_q    <= 8'h00;
        bsy_q    <= 1'b0;
        if (host_wdata[7:0] == CMD_SETFEAT && feat_q == FEAT_XFER) begin
          xfer_class <= count_q[7:3];
          xfer_mode  <= count_q[2:0];
        end
      end
    end
  end

  always_comb begin
    case (host_addr)
      ADR_DATA:    host_rdata = st_active ? st_word : 16'h0000;
      ADR_ERRFEAT: host_rdata = {8'h00, err_q};
      ADR_COUNT:   host_rdata = {8'h00, count_q};
      ADR_SECTOR:  host_rdata = {8'h00, sector_q};
      ADR_BCLO:    host_rdata = {8'h00, bclo_q};
      ADR_BCHI:    host_rdata = {8'h00, bchi_q};
      ADR_DEVICE:  host_rdata = {8'h00, dev_q};
      ADR_STATCMD,
      ADR_ALTCTL:  host_rdata = {8'h00, status};
      default:     host_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/atapi_tf_ctrl_chk.sv
module atapi_tf_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic [3:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic        irq,
  input logic        irq_pend,
  input logic        irq_raise,
  input logic        bsy,
  input logic        drq,
  input logic        pkt_last
);
  p_cmd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'd7 && !irq_raise |=> !irq_pend);

  p_last_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_last |=> bsy && !drq && irq_pend);

  p_busy_nodrq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bsy |-> !drq);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 4'd7 && bsy && irq_pend && !host_wr |=> irq_pend);

  p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 4'd7 && !bsy && !irq_raise && !host_wr |=> !irq_pend);

  p_alt_noack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 4'd8 && irq_pend && !host_wr |=> irq_pend);

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'd8 && host_wdata[1] |=> !irq);

  p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'd8 && irq_pend && !host_rd |=> irq_pend);
endmodule

bind atapi_tf_ctrl atapi_tf_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .irq(irq),
  .irq_pend(irq_pend), .irq_raise(irq_raise), .bsy(bsy_q), .drq(drq),
  .pkt_last(pkt_last)
);

// File: tb/atapi_tf_ctrl_tb_top.sv
`timescale 1ns/1ps
module atapi_tf_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        medium_present = 1'b0;
  logic        irq;
  logic [4:0]  xfer_class;
  logic [2:0]  xfer_mode;

  always #2.5 clk = ~clk;

  atapi_tf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .medium_present(medium_present), .irq(irq),
    .xfer_class(xfer_class), .xfer_mode(xfer_mode)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [15:0] w0, w1, w2, w3, w4, w5);
    wr(4'd7, 16'h00A0);
    wr(4'd0, w0); wr(4'd0, w1); wr(4'd0, w2);
    wr(4'd0, w3); wr(4'd0, w4); wr(4'd0, w5);
  endtask

  // {write, addr, data}; for reads data is the expected value
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd7, 16'h0000}, {1'b0, 4'd6, 16'h0000}, {1'b0, 4'd1, 16'h0000},
    {1'b0, 4'd3, 16'h0081}, {1'b1, 4'd6, 16'h00A5}, {1'b0, 4'd6, 16'h00A5},
    {1'b1, 4'd4, 16'h0033}, {1'b1, 4'd5, 16'h0001}, {1'b0, 4'd4, 16'h0033},
    {1'b0, 4'd5, 16'h0001}
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:0]);
      else begin
        rd(VEC[i][19:16], d);
        chk("R1 reset/register vector", d, VEC[i][15:0]);
      end
    end

    // set features
    wr(4'd2, 16'h001A); wr(4'd1, 16'h0003); wr(4'd7, 16'h00EF);
    chk("R11 irq raised", irq, 1);
    chk("R11 class", xfer_class, 3);
    chk("R11 mode", xfer_mode, 2);
    rd(4'd8, d); chk("R4 alt status value", d, 16'h0050);
    chk("R4 alt read keeps irq", irq, 1);
    wr(4'd8, 16'h0002); chk("R5 masked irq", irq, 0);
    wr(4'd8, 16'h0000); chk("R5 unmask reasserts", irq, 1);
    rd(4'd7, d); chk("R4 status value", d, 16'h0050);
    chk("R4 status read acks", irq, 0);
    wr(4'd2, 16'h0022); wr(4'd1, 16'h0005); wr(4'd7, 16'h00EF);
    chk("R11 other feature class kept", xfer_class, 3);
    chk("R11 other feature irq", irq, 1);
    wr(4'd7, 16'h0000);
    chk("R2 command clears irq", irq, 0);
    rd(4'd7, d); chk("R2 status DRDY SERV", d, 16'h0050);

    // data write while not armed
    wr(4'd0, 16'h1234);
    rd(4'd7, d); chk("R12 stray data write", d, 16'h0050);
    rd(4'd0, d); chk("R8 idle data read", d, 16'h0000);

    // identify, 20 bytes, 8-byte blocks
    wr(4'd4, 16'h0008); wr(4'd5, 16'h0000);
    wr(4'd7, 16'h00A0);
    rd(4'd7, d); chk("R3 DRQ after packet cmd", d, 16'h0058);
    wr(4'd0, 16'h0012); wr(4'd0, 16'h0014);
    wr(4'd0, 16'h0000); wr(4'd0, 16'h0000); wr(4'd0, 16'h0000);
    rd(4'd7, d); chk("R3 DRQ before last word", d, 16'h0058);
    wr(4'd0, 16'h0000);
    rd(4'd7, d); chk("R3 busy after last word", d, 16'h00D0);
    chk("R3 irq on packet", irq, 1);
    rd(4'd7, d); chk("R4 busy status", d, 16'h00D0);
    chk("R4 no ack while busy", irq, 1);
    rd(4'd7, d); chk("R4 status after decode", d, 16'h0058);
    chk("R4 ack after busy", irq, 0);
    rd(4'd4, d); chk("R6 length written back", d, 16'h0014);
    for (int k = 0; k < 10; k++) begin
      rd(4'd0, d);
      chk("R6 ident word", d, {8'h41 + 8'(2*k), 8'h40 + 8'(2*k)});
      if (k == 3 || k == 7) begin
        chk("R7 block irq", irq, 1);
        rd(4'd7, d);
      end else begin
        chk("R7 no irq mid-block", irq, 0);
      end
    end
    rd(4'd7, d); chk("R8 DRQ cleared", d, 16'h0050);
    rd(4'd0, d); chk("R8 read after end", d, 16'h0000);

    // identify clipped to 32 bytes, block size 0
    wr(4'd4, 16'h0000); wr(4'd5, 16'h0000);
    send_pkt(16'h0012, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    idle(3);
    rd(4'd7, d); chk("R6 clipped stream DRQ", d, 16'h0058);
    rd(4'd4, d); chk("R6 clipped length", d, 16'h0020);
    for (int k = 0; k < 16; k++) begin
      rd(4'd0, d);
      if (k == 15) chk("R6 last ident word", d, 16'h5F5E);
    end
    chk("R7 size zero no block irq", irq, 0);
    rd(4'd7, d); chk("R8 clipped end", d, 16'h0050);

    // read sector, no medium
    medium_present = 1'b0;
    send_pkt(16'h0030, 16'h2301, 16'h0045, 16'h0000, 16'h0000, 16'h0002);
    idle(3);
    rd(4'd7, d); chk("R9 ERR status", d, 16'h0051);
    rd(4'd1, d); chk("R9 error code", d, 16'h0050);
    wr(4'd7, 16'h0000);
    rd(4'd7, d); chk("R2 ERR cleared", d, 16'h0050);
    rd(4'd1, d); chk("R2 error code cleared", d, 16'h0000);

    // read sector with medium, 2 blocks, 8-byte host blocks
    medium_present = 1'b1;
    wr(4'd4, 16'h0008); wr(4'd5, 16'h0000);
    send_pkt(16'h0030, 16'h2301, 16'h0045, 16'h0000, 16'h0000, 16'h0002);
    idle(3);
    rd(4'd7, d); chk("R10 DRQ", d, 16'h0058);
    for (int k = 0; k < 8; k++) begin
      rd(4'd0, d);
      chk("R10 sector word", d, 16'h2345 + 16'(k));
      if (k == 3) begin
        chk("R7 sector block irq", irq, 1);
        rd(4'd7, d);
      end
    end
    rd(4'd7, d); chk("R10 end of sectors", d, 16'h0050);
    chk("R10 no irq at end", irq, 0);

    // reset again
    wr(4'd3, 16'h0011);
    rst_n = 1'b0; idle(2); rst_n = 1'b1; @(negedge clk);
    rd(4'd3, d); chk("R1 sector reload", d, 16'h0081);
    rd(4'd7, d); chk("R1 status cleared", d, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule